// File: doc/BRIEF.md
# Hierarchical Global Miss Detector for a Tiled Cache Tree

This block decides, for each search request, whether the request has missed in every tile of a cache built as a tree of small tiles. A search enters at the root tile. It then moves one tree level per clock cycle towards the leaves. At each level every tile that holds the search compares the address against its stored block address. A tile that hits keeps the search from going into its own subtree.

When the search has passed the leaf level, the miss flags of the leaves are combined through a layered AND tree that follows the shape of the tile tree. The combined outcome is registered one cycle after the leaf lookup. A request is declared a global miss only when it reached every leaf and every leaf missed. The result carries the full request: address, miss-status-register index, store data and control bits. The next memory level can therefore receive the request at once. The tree accepts one new search in every cycle and has no back-pressure. Tag contents come in as inputs.

Top module: `lnm_miss_detect`

## Requirements
- R1: A search with `req_vld` high is sampled at a rising edge, and a new one may be sampled at every edge. Each sampled search produces exactly one result with `gm_vld` high, exactly LEVELS edges after the sampling edge, and results appear in issue order.
- R2: Tiles are numbered breadth-first: the root is 0 and the children of tile n are n*FANOUT+1 through n*FANOUT+FANOUT. Tile n takes its stored address from bits n*41 up to n*41+40 of `tag_addr` and its valid flag from bit n of `tag_vld`. It hits when it holds the search, its flag is set and the stored address equals the search address.
- R3: A tile that hits does not pass the search to its children, so no tile in its subtree looks the search up.
- R4: `gm_miss` is 1 for a result if and only if every leaf tile held the search and missed. A hit at any tile of any level forces it to 0.
- R5: A result repeats the address, the 4-bit miss-status-register index, the 64-bit store data and the 2-bit control field of the search it belongs to.
- R6: Searches issued back to back with different outcomes each get their own outcome, with no mixing between requests in flight.
- R7: While `rst` is high, and after it falls, `gm_vld` and `gm_miss` are 0, and searches in flight when reset rose produce no result.
- R8: A cycle with `req_vld` low produces no result, and `gm_miss` is 0 whenever `gm_vld` is 0.
- R9: A tile whose `tag_vld` bit is 0 never hits, even when its stored address equals the search address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Search present this cycle |
| req_addr | input | 41 | Search block address |
| req_mshr | input | 4 | Miss-status-register index of the search |
| req_stdata | input | 64 | Store data carried with the search |
| req_ctrl | input | 2 | Control bits carried with the search |
| tag_vld | input | NT | Per-tile stored-block valid flags |
| tag_addr | input | NT*41 | Per-tile stored block addresses, tile n at bits n*41 upward |
| gm_vld | output | 1 | Outcome for one search is present |
| gm_miss | output | 1 | The search missed in every tile |
| gm_addr | output | 41 | Address of the search the outcome belongs to |
| gm_mshr | output | 4 | Miss-status-register index of that search |
| gm_stdata | output | 64 | Store data of that search |
| gm_ctrl | output | 2 | Control bits of that search |

## Verification
The bench builds the block with FANOUT=2 and LEVELS=3. That gives seven tiles on three levels with four leaves, and a combining tree with two AND layers. This size is enough to place a hit at the root, at a middle tile, at the first and last leaves, and under an ancestor that already hit. Each of these outcomes is checked against a reference that scans all tiles. Searches are issued back to back and with gaps, so that results with different outcomes follow each other. One reset lands while searches are still in flight.

// File: rtl/lnm_pkg.sv
package lnm_pkg;

    localparam int ADDR_W = 41;
    localparam int MSHR_W = 4;
    localparam int DATA_W = 64;
    localparam int CTRL_W = 2;

    // one search broadcast word plus its valid bit
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [MSHR_W-1:0] mshr;
        logic [DATA_W-1:0] stdata;
        logic [CTRL_W-1:0] ctrl;
    } srch_t;

    function automatic int ipow(input int b, input int e);
        int r;
        r = 1;
        for (int i = 0; i < e; i++) r = r * b;
        return r;
    endfunction

    // index of the first tile of level k (breadth-first numbering)
    function automatic int level_base(input int f, input int k);
        int s;
        s = 0;
        for (int i = 0; i < k; i++) s = s + ipow(f, i);
        return s;
    endfunction

    function automatic int tile_count(input int f, input int l);
        return level_base(f, l);
    endfunction

    // tree level that holds tile n
    function automatic int level_of(input int f, input int n);
        int rem;
        int w;
        int lv;
        rem = n;
        w   = 1;
        lv  = 0;
        while (rem >= w) begin
            rem = rem - w;
            w   = w * f;
            lv  = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/lnm_tile_cmp.sv
module lnm_tile_cmp
    import lnm_pkg::*;
(
    input  logic              held,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tag_vld,
    input  logic [ADDR_W-1:0] tag_addr,
    output logic              hit,
    output logic              miss
);

    always_comb begin
        hit  = held && tag_vld && (tag_addr == addr);
        miss = held && !hit;
    end

endmodule

// File: rtl/lnm_search_pipe.sv
module lnm_search_pipe
    import lnm_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  srch_t             in_srch,
    output logic [ADDR_W-1:0] stage_addr [DEPTH],
    output srch_t             tail
);

    logic  vld_q [DEPTH];
    srch_t pay_q [DEPTH];

    // only the valid bits are reset; payload is qualified by them
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
        end else begin
            vld_q[0] <= in_srch.vld;
            for (int i = 1; i < DEPTH; i++) vld_q[i] <= vld_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        pay_q[0] <= in_srch;
        for (int i = 1; i < DEPTH; i++) pay_q[i] <= pay_q[i-1];
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_addr
        assign stage_addr[g] = pay_q[g].addr;
    end

    always_comb begin
        tail     = pay_q[DEPTH-1];
        tail.vld = vld_q[DEPTH-1];
    end

endmodule

// File: rtl/lnm_and_tree.sv
module lnm_and_tree
    import lnm_pkg::*;
#(
    parameter int FANOUT = 2,
    parameter int LEVELS = 3,
    localparam int NLEAF = ipow(FANOUT, LEVELS - 1)
) (
    input  logic [NLEAF-1:0] leaf,
    output logic             all_miss
);

    // layer 0 holds the leaves; each higher layer groups FANOUT nodes
    for (genvar j = 0; j < LEVELS; j++) begin : g_lay
        localparam int W = ipow(FANOUT, LEVELS - 1 - j);
        logic [W-1:0] v;
        if (j == 0) begin : g_leaf
            assign v = leaf;
        end else begin : g_node
            for (genvar i = 0; i < W; i++) begin : g_grp
                assign v[i] = &g_lay[j-1].v[i*FANOUT +: FANOUT];
            end
        end
    end

    assign all_miss = g_lay[LEVELS-1].v[0];

endmodule

// File: rtl/lnm_miss_detect.sv
module lnm_miss_detect
    import lnm_pkg::*;
#(
    parameter int FANOUT = 2,
    parameter int LEVELS = 3,
    localparam int NT        = tile_count(FANOUT, LEVELS),
    localparam int LEAF_BASE = level_base(FANOUT, LEVELS - 1),
    localparam int NLEAF     = NT - LEAF_BASE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_vld,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [MSHR_W-1:0]    req_mshr,
    input  logic [DATA_W-1:0]    req_stdata,
    input  logic [CTRL_W-1:0]    req_ctrl,
    input  logic [NT-1:0]        tag_vld,
    input  logic [NT*ADDR_W-1:0] tag_addr,
    output logic                 gm_vld,
    output logic                 gm_miss,
    output logic [ADDR_W-1:0]    gm_addr,
    output logic [MSHR_W-1:0]    gm_mshr,
    output logic [DATA_W-1:0]    gm_stdata,
    output logic [CTRL_W-1:0]    gm_ctrl
);

    srch_t             req_s;
    logic [ADDR_W-1:0] stg_addr [LEVELS];
    srch_t             tail;
    logic [NT-1:0]     held;
    logic [NT-1:0]     held_nxt;
    logic [NT-1:0]     hit;
    logic [NT-1:0]     miss;
    logic [NLEAF-1:0]  leaf_miss;
    logic              all_miss;

    always_comb begin
        req_s.vld    = req_vld;
        req_s.addr   = req_addr;
        req_s.mshr   = req_mshr;
        req_s.stdata = req_stdata;
        req_s.ctrl   = req_ctrl;
    end

    // per-level shared search word; tiles keep only a valid bit
    lnm_search_pipe #(.DEPTH(LEVELS)) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .in_srch    (req_s),
        .stage_addr (stg_addr),
        .tail       (tail)
    );

    for (genvar n = 0; n < NT; n++) begin : g_tile
        localparam int LV = level_of(FANOUT, n);
        lnm_tile_cmp u_cmp (
            .held     (held[n]),
            .addr     (stg_addr[LV]),
            .tag_vld  (tag_vld[n]),
            .tag_addr (tag_addr[n*ADDR_W +: ADDR_W]),
            .hit      (hit[n]),
            .miss     (miss[n])
        );
    end

    // a child holds the search only when its parent held it and missed
    always_comb begin
        held_nxt[0] = req_vld;
        for (int n = 1; n < NT; n++) held_nxt[n] = miss[(n - 1) / FANOUT];
    end

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else     held <= held_nxt;
    end

    assign leaf_miss = miss[NT-1:LEAF_BASE];

    lnm_and_tree #(.FANOUT(FANOUT), .LEVELS(LEVELS)) u_tree (
        .leaf     (leaf_miss),
        .all_miss (all_miss)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gm_vld  <= 1'b0;
            gm_miss <= 1'b0;
        end else begin
            gm_vld  <= tail.vld;
            gm_miss <= tail.vld && all_miss;
        end
    end

    always_ff @(posedge clk) begin
        gm_addr   <= tail.addr;
        gm_mshr   <= tail.mshr;
        gm_stdata <= tail.stdata;
        gm_ctrl   <= tail.ctrl;
    end

    // ---------------- assertions ----------------
    AST_MISS_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
        gm_miss |-> gm_vld); // R8

    AST_TREE_FLAT: assert property (@(posedge clk) disable iff (rst)
        all_miss == (&leaf_miss)); // R4

    AST_MISS_ALL_LEAVES: assert property (@(posedge clk) disable iff (rst)
        gm_miss |-> $past(&held[NT-1:LEAF_BASE])); // R4

    AST_LEAF_HAS_WORD: assert property (@(posedge clk) disable iff (rst)
        (|held[NT-1:LEAF_BASE]) |-> tail.vld); // R6

    for (genvar p = 0; p < LEAF_BASE; p++) begin : g_cut
        AST_HIT_CUTS: assert property (@(posedge clk) disable iff (rst)
            hit[p] |=> (held[p*FANOUT+1 +: FANOUT] == '0)); // R3
    end

endmodule

// File: tb/test_lnm_miss_detect.sv
`timescale 1ns/1ps
module test_lnm_miss_detect;
    import lnm_pkg::*;

    localparam int FANOUT = 2;
    localparam int LEVELS = 3;
    localparam int NT     = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst;
    logic                 req_vld;
    logic [ADDR_W-1:0]    req_addr;
    logic [MSHR_W-1:0]    req_mshr;
    logic [DATA_W-1:0]    req_stdata;
    logic [CTRL_W-1:0]    req_ctrl;
    logic [NT-1:0]        tag_vld;
    logic [NT*ADDR_W-1:0] tag_addr;
    logic                 gm_vld, gm_miss;
    logic [ADDR_W-1:0]    gm_addr;
    logic [MSHR_W-1:0]    gm_mshr;
    logic [DATA_W-1:0]    gm_stdata;
    logic [CTRL_W-1:0]    gm_ctrl;

    logic [ADDR_W-1:0] ta [NT];

    always_comb begin
        for (int n = 0; n < NT; n++) tag_addr[n*ADDR_W +: ADDR_W] = ta[n];
    end

    lnm_miss_detect #(.FANOUT(FANOUT), .LEVELS(LEVELS)) i_lnm_miss_detect (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
        .req_mshr(req_mshr), .req_stdata(req_stdata), .req_ctrl(req_ctrl),
        .tag_vld(tag_vld), .tag_addr(tag_addr), .gm_vld(gm_vld),
        .gm_miss(gm_miss), .gm_addr(gm_addr), .gm_mshr(gm_mshr),
        .gm_stdata(gm_stdata), .gm_ctrl(gm_ctrl)
    );

    typedef struct {
        logic              miss;
        logic [ADDR_W-1:0] addr;
        logic [MSHR_W-1:0] mshr;
        logic [DATA_W-1:0] data;
        logic [CTRL_W-1:0] ctrl;
        int                due;
        string             rq;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // reference: a global miss happens exactly when no tile at all hits
    function automatic logic ref_miss(input logic [ADDR_W-1:0] a);
        for (int n = 0; n < NT; n++)
            if (tag_vld[n] && ta[n] == a) return 1'b0;
        return 1'b1;
    endfunction

    task automatic issue(input logic [ADDR_W-1:0] a, input logic [MSHR_W-1:0] m,
                         input logic [DATA_W-1:0] d, input logic [CTRL_W-1:0] c,
                         input string rq);
        exp_t e;
        @(negedge clk);
        req_vld    = 1'b1;
        req_addr   = a;
        req_mshr   = m;
        req_stdata = d;
        req_ctrl   = c;
        e.miss = ref_miss(a);
        e.addr = a;
        e.mshr = m;
        e.data = d;
        e.ctrl = c;
        e.due  = cyc + 1 + LEVELS;
        e.rq   = rq;
        sb.push_back(e);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            req_vld = 1'b0;
        end
    endtask

    task automatic drain();
        idle(1);
        while (sb.size() != 0) idle(1);
        idle(2);
    endtask

    task automatic clear_tags();
        tag_vld = '0;
        for (int n = 0; n < NT; n++) ta[n] = 41'h1_0000_0000 + 41'(n);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            while (sb.size() != 0 && sb[0].due < cyc) begin
                chk(1'b0, "R1", "missing result", 64'(0), 64'(sb[0].due));
                void'(sb.pop_front());
            end
            if (gm_vld) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8", "unexpected result", 64'(1), 64'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.due, "R1", "result cycle", 64'(cyc), 64'(e.due));
                    chk(gm_miss == e.miss, e.rq, "global miss", 64'(gm_miss), 64'(e.miss));
                    chk(gm_addr == e.addr && gm_mshr == e.mshr, "R5", "addr/mshr",
                        64'({gm_mshr, gm_addr}), 64'({e.mshr, e.addr}));
                    chk(gm_stdata == e.data && gm_ctrl == e.ctrl, "R5", "data/ctrl",
                        gm_stdata ^ 64'(gm_ctrl), e.data ^ 64'(e.ctrl));
                end
            end else begin
                chk(gm_miss == 1'b0, "R8", "miss without valid", 64'(gm_miss), 64'(0));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_vld = 1'b0;
        req_addr = '0;
        req_mshr = '0;
        req_stdata = '0;
        req_ctrl = '0;
        clear_tags();
        repeat (3) @(negedge clk);
        chk(gm_vld == 1'b0 && gm_miss == 1'b0, "R7", "in reset", 64'({gm_vld, gm_miss}), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(gm_vld == 1'b0 && gm_miss == 1'b0, "R7", "after reset", 64'({gm_vld, gm_miss}), 64'(0));

        // all tiles empty: every search misses everywhere
        issue(41'h0_1234_5678, 4'h1, 64'hDEAD_BEEF_0000_0001, 2'b01, "R4");
        issue(41'h1_0000_0000, 4'h2, 64'h0123_4567_89AB_CDEF, 2'b10, "R9");
        drain();

        // hit at the root
        ta[0] = 41'h0_0000_0A00; tag_vld[0] = 1'b1;
        issue(41'h0_0000_0A00, 4'h3, 64'h1111, 2'b11, "R3");
        issue(41'h0_0000_0A01, 4'h4, 64'h2222, 2'b00, "R4");
        drain();
        clear_tags();

        // hit in a middle tile (tile 2) and the first and last leaves
        ta[2] = 41'h0_0000_0B02; tag_vld[2] = 1'b1;
        ta[3] = 41'h0_0000_0B03; tag_vld[3] = 1'b1;
        ta[6] = 41'h1_FFFF_FFFF; tag_vld[6] = 1'b1;
        issue(41'h0_0000_0B02, 4'h5, 64'h3333, 2'b01, "R2");
        issue(41'h0_0000_0B03, 4'h6, 64'h4444, 2'b10, "R2");
        issue(41'h1_FFFF_FFFF, 4'h7, 64'h5555, 2'b11, "R2");
        issue(41'h0_0000_0B04, 4'h8, 64'h6666, 2'b00, "R4");
        drain();
        clear_tags();

        // a leaf under an ancestor that already hit: still no miss
        ta[1] = 41'h0_0000_0C00; tag_vld[1] = 1'b1;
        ta[4] = 41'h0_0000_0C00; tag_vld[4] = 1'b1;
        issue(41'h0_0000_0C00, 4'h9, 64'h7777, 2'b01, "R3");
        drain();
        clear_tags();

        // matching address in a tile whose valid flag is clear
        ta[5] = 41'h0_0000_0D05; tag_vld[5] = 1'b0;
        issue(41'h0_0000_0D05, 4'hA, 64'h8888, 2'b10, "R9");
        drain();
        clear_tags();

        // back-to-back stream with mixed outcomes
        ta[1] = 41'h0_0000_0E01; tag_vld[1] = 1'b1;
        ta[4] = 41'h0_0000_0E04; tag_vld[4] = 1'b1;
        ta[6] = 41'h0_0000_0E06; tag_vld[6] = 1'b1;
        for (int i = 0; i < 24; i++) begin
            logic [ADDR_W-1:0] a;
            case (i % 5)
                0: a = 41'h0_0000_0E01;
                1: a = 41'h0_0000_0E04;
                2: a = 41'h0_0000_0F00 + 41'(i);
                3: a = 41'h0_0000_0E06;
                default: a = 41'h0_0000_0E05;
            endcase
            issue(a, 4'(i), 64'hA5A5_0000_0000_0000 + 64'(i), 2'(i), "R6");
        end
        drain();

        // gaps between searches
        issue(41'h0_0000_0E04, 4'hB, 64'h9999, 2'b01, "R8");
        idle(2);
        issue(41'h0_0000_0F77, 4'hC, 64'hAAAA, 2'b10, "R8");
        idle(1);
        issue(41'h0_0000_0E01, 4'hD, 64'hBBBB, 2'b11, "R8");
        drain();

        // reset while searches are in flight
        issue(41'h0_0000_0F10, 4'hE, 64'hCCCC, 2'b00, "R7");
        issue(41'h0_0000_0F11, 4'hF, 64'hDDDD, 2'b01, "R7");
        @(negedge clk);
        req_vld = 1'b0;
        rst = 1'b1;
        sb.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LEVELS + 3; i++) begin
            @(negedge clk);
            chk(gm_vld == 1'b0, "R7", "stale result after reset", 64'(gm_vld), 64'(0));
        end

        drain();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule